// File: doc/BRIEF.md
# Dual-Port Line Delay Memory

This block stores one image scan line of 1152 eight-bit pixels and plays it back on a second, fully independent port. The write side and the read side each have their own clock, an active-low enable and an active-low pointer reset. Each side owns an address pointer that steps once per enabled clock and wraps at the end of the line. There are no full or empty flags. The delay between input and output comes only from when the two pointer resets are applied.

A typical use is a one-line delay for vertical image filters. Both resets are pulsed in the same cycle, both enables are held active, and the output then carries the pixel that was written exactly one line earlier. Shorter delays come from starting the read reset later than the write reset. The read port reports an output-enable flag that stands in for a tri-state bus. While the flag is low the data lines read zero. A global synchronous power-on reset clears both pointers and turns the output off. It leaves the stored pixels undefined.

Top module: `line_delay_mem`

## Requirements
- R1: With `wr_en_n` low, each rising `wr_clk` edge samples `wr_data` for the word at the write pointer, and the write pointer steps by one.
- R2: With `wr_en_n` high, no word is changed and the write pointer keeps its value.
- R3: With `rd_en_n` low, each rising `rd_clk` edge loads the word at the read pointer onto `rd_data`, sets `rd_oe` to 1 and steps the read pointer by one.
- R4: With `rd_en_n` high, the read pointer keeps its value, and after the edge `rd_oe` is 0 and `rd_data` is 0 (high impedance).
- R5: A low pointer reset sampled on its own port's clock moves only that port's pointer to word 0. If the enable is also low, word 0 is accessed in that same cycle and the pointer is at word 1 in the next cycle. The other port's pointer is not affected.
- R6: A pointer that steps past word 1151 continues at word 0, on both ports.
- R7: A sampled write reaches the array on the next rising `wr_clk` edge. A read of that word on the sampling edge or on the following edge returns the old content. A read on any later edge returns the new content.
- R8: When both resets are applied in the same cycle on a common clock and both enables stay low, `rd_data` in each cycle equals the `wr_data` sampled 1152 cycles earlier.
- R9: While `por_n` is low, both pointers are cleared, and after the edge `rd_oe` is 0 and `rd_data` is 0. The first enabled accesses after release start at word 0.
- R10: A read reset applied while `rd_en_n` is high clears the read pointer without driving the output. The next enabled read returns word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Global power-on reset, active low, sampled on both clocks |
| wr_clk | input | 1 | Write-side clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_rst_n | input | 1 | Write pointer reset, active low |
| wr_data | input | 8 | Pixel to store |
| rd_clk | input | 1 | Read-side clock |
| rd_en_n | input | 1 | Read enable, active low |
| rd_rst_n | input | 1 | Read pointer reset, active low |
| rd_oe | output | 1 | 1 while `rd_data` is driven; 0 means high impedance |
| rd_data | output | 8 | Pixel read out, 0 while `rd_oe` is 0 |

## Verification
The hard case is a read and a pending write commit that land on the same edge at the same address. The bench writes a new value to word 0 through a write reset, then reads word 0 through read resets on that edge, the next edge and the one after. It expects the old value twice and then the new one. A pointer reset combined with an enable is also driven in the same cycle on both ports. In that case the scoreboard expects word 0 to be accessed at once and word 1 to follow.

// File: rtl/lmem_pkg.sv
`timescale 1ns/1ps
// Package lmem_pkg
// Shared defaults and pointer arithmetic for the line delay memory.
// Assumes line lengths fit in 32 bits.
package lmem_pkg;

    localparam int unsigned LMEM_WORDS_DEF = 1152;
    localparam int unsigned LMEM_WIDTH_DEF = 8;

    // Next pointer value with wrap at the end of the line.
    function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned words);
        return (cur + 1 >= words) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/lmem_addr_ctr.sv
`timescale 1ns/1ps
// Module lmem_addr_ctr
// Pointer for one port. It steps while enabled, holds while disabled and
// returns to word 0 on its own reset. Reset has priority over enable, so the
// reset cycle accesses word 0 itself.
// Assumes WORDS > 1 and that por_n is synchronous to clk.
module lmem_addr_ctr
    import lmem_pkg::*;
#(
    parameter  int unsigned WORDS = LMEM_WORDS_DEF,
    localparam int unsigned AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          clr_n,
    input  logic          en_n,
    output logic [AW-1:0] acc_addr,
    output logic          acc_go
);

    localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

    logic [AW-1:0] ptr_q;

    // Address used this cycle: a reset forces word 0.
    always_comb acc_addr = clr_n ? ptr_q : '0;

    // Access happens only out of power-on reset and with the enable active.
    always_comb acc_go = por_n && !en_n;

    // Pointer register: clear, step with wrap, or hold.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            ptr_q <= '0;
        end else if (acc_go) begin
            ptr_q <= AW'(wrap_next(32'(acc_addr), WORDS));
        end else begin
            ptr_q <= acc_addr;
        end
    end

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!por_n)
        (acc_go && acc_addr == LAST) |=> (ptr_q == '0));

    // Disabled port without reset keeps its pointer (R2 on write, R4 on read).
    assert_hold_R2: assert property (@(posedge clk) disable iff (!por_n)
        (en_n && clr_n) |=> $stable(ptr_q));

    assert_rst_step_R5: assert property (@(posedge clk) disable iff (!por_n)
        (!clr_n && !en_n) |=> (ptr_q == AW'(1)));

    assert_rst_idle_R10: assert property (@(posedge clk) disable iff (!por_n)
        (!clr_n && en_n) |=> (ptr_q == '0));

endmodule

// File: rtl/lmem_wr_stage.sv
`timescale 1ns/1ps
// Module lmem_wr_stage
// Holds one sampled write for a clock, so the array is updated on the
// write-clock edge after the data was sampled.
// Assumes por_n is synchronous to clk.
module lmem_wr_stage #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          go,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          pend_v,
    output logic [AW-1:0] pend_a,
    output logic [DW-1:0] pend_d
);

    // Valid flag: set for each accepted write, dropped by power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n) pend_v <= 1'b0;
        else        pend_v <= go;
    end

    // Address and data capture; no reset is needed on the payload.
    always_ff @(posedge clk) begin
        if (go) begin
            pend_a <= addr;
            pend_d <= din;
        end
    end

endmodule

// File: rtl/lmem_array.sv
`timescale 1ns/1ps
// Module lmem_array
// Storage array with a commit port on the write clock and a registered read
// port on the read clock. The read port drives zero with the enable flag low
// when idle. A read and a commit to the same word on one edge return the old word.
// Assumes por_n is synchronous to both clocks.
module lmem_array #(
    parameter int unsigned WORDS = 1152,
    parameter int unsigned DW    = 8,
    parameter int unsigned AW    = 11
) (
    input  logic          wr_clk,
    input  logic          cm_v,
    input  logic [AW-1:0] cm_a,
    input  logic [DW-1:0] cm_d,
    input  logic          rd_clk,
    input  logic          por_n,
    input  logic          rd_go,
    input  logic [AW-1:0] rd_a,
    output logic          rd_oe,
    output logic [DW-1:0] rd_q
);

    logic [DW-1:0] mem [WORDS];

    // Commit of the staged write.
    always_ff @(posedge wr_clk) begin
        if (cm_v) mem[cm_a] <= cm_d;
    end

    // Read register and output-enable flag.
    always_ff @(posedge rd_clk) begin
        if (!por_n) begin
            rd_oe <= 1'b0;
            rd_q  <= '0;
        end else if (rd_go) begin
            rd_oe <= 1'b1;
            rd_q  <= mem[rd_a];
        end else begin
            rd_oe <= 1'b0;
            rd_q  <= '0;
        end
    end

    assert_commit_R7: assert property (@(posedge wr_clk) disable iff (!por_n)
        cm_v |=> (mem[$past(cm_a)] == $past(cm_d)));

    assert_drive_R3: assert property (@(posedge rd_clk) disable iff (!por_n)
        rd_go |=> rd_oe);

    assert_float_R4: assert property (@(posedge rd_clk) disable iff (!por_n)
        !rd_go |=> (!rd_oe && rd_q == '0));

endmodule

// File: rtl/line_delay_mem.sv
`timescale 1ns/1ps
// Module line_delay_mem
// One-line delay memory with independent write and read ports. Each port has
// its own pointer with an active-low enable and an active-low reset. Storage
// contents are undefined after power-on.
// Assumes por_n is released synchronously to both clocks.
module line_delay_mem
    import lmem_pkg::*;
#(
    parameter  int unsigned WORDS = LMEM_WORDS_DEF,
    parameter  int unsigned DW    = LMEM_WIDTH_DEF,
    localparam int unsigned AW    = $clog2(WORDS)
) (
    input  logic          por_n,
    input  logic          wr_clk,
    input  logic          wr_en_n,
    input  logic          wr_rst_n,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_en_n,
    input  logic          rd_rst_n,
    output logic          rd_oe,
    output logic [DW-1:0] rd_data
);

    logic [AW-1:0] w_addr, r_addr, pend_a;
    logic          w_go, r_go, pend_v;
    logic [DW-1:0] pend_d;

    // Write pointer.
    lmem_addr_ctr #(.WORDS(WORDS)) i_wr_ctr (
        .clk(wr_clk), .por_n(por_n), .clr_n(wr_rst_n), .en_n(wr_en_n),
        .acc_addr(w_addr), .acc_go(w_go)
    );

    // Read pointer.
    lmem_addr_ctr #(.WORDS(WORDS)) i_rd_ctr (
        .clk(rd_clk), .por_n(por_n), .clr_n(rd_rst_n), .en_n(rd_en_n),
        .acc_addr(r_addr), .acc_go(r_go)
    );

    // One-cycle write staging.
    lmem_wr_stage #(.AW(AW), .DW(DW)) i_stage (
        .clk(wr_clk), .por_n(por_n), .go(w_go), .addr(w_addr), .din(wr_data),
        .pend_v(pend_v), .pend_a(pend_a), .pend_d(pend_d)
    );

    // Storage and read port.
    lmem_array #(.WORDS(WORDS), .DW(DW), .AW(AW)) i_array (
        .wr_clk(wr_clk), .cm_v(pend_v), .cm_a(pend_a), .cm_d(pend_d),
        .rd_clk(rd_clk), .por_n(por_n), .rd_go(r_go), .rd_a(r_addr),
        .rd_oe(rd_oe), .rd_q(rd_data)
    );

    assert_por_R9: assert property (@(posedge rd_clk)
        $fell(por_n) |=> (!rd_oe && rd_data == '0));

endmodule

// File: tb/test_line_delay_mem.sv
`timescale 1ns/1ps
module test_line_delay_mem;

    localparam int W = 1152;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       wr_en_n = 1'b1, wr_rst_n = 1'b1, rd_en_n = 1'b1, rd_rst_n = 1'b1;
    logic [7:0] wr_data = '0;
    logic       rd_oe;
    logic [7:0] rd_data;

    always #2 clk = ~clk;   // 250 MHz

    line_delay_mem i_line_delay_mem (
        .por_n(por_n), .wr_clk(clk), .wr_en_n(wr_en_n), .wr_rst_n(wr_rst_n),
        .wr_data(wr_data), .rd_clk(clk), .rd_en_n(rd_en_n), .rd_rst_n(rd_rst_n),
        .rd_oe(rd_oe), .rd_data(rd_data)
    );

    // Reference model state, built from the requirements.
    logic [7:0] mm [W];
    bit         kn [W];
    int         wptr = 0, rptr = 0, pa = 0;
    bit         pv = 0;
    logic [7:0] pd = '0;

    // Scoreboard: {oe, data, compare-data} plus a tag.
    logic [9:0] exp_q [$];
    string      tag_q [$];
    int         checks = 0, errors = 0;
    bit         done = 0;

    // Driver: one clock of stimulus; pushes the expected output of that edge.
    task automatic step(input bit pn, input bit wen, input bit wrst, input logic [7:0] wd,
                        input bit ren, input bit rrst, input string tag);
        bit eoe, ek;
        logic [7:0] ed;
        int ra, wa;
        @(negedge clk);
        por_n = pn; wr_en_n = !wen; wr_rst_n = !wrst; wr_data = wd;
        rd_en_n = !ren; rd_rst_n = !rrst;
        if (!pn) begin
            eoe = 0; ed = 0; ek = 1; wptr = 0; rptr = 0; pv = 0;
        end else begin
            ra = rrst ? 0 : rptr;
            if (ren) begin
                eoe = 1; ed = mm[ra]; ek = kn[ra]; rptr = (ra + 1) % W;
            end else begin
                eoe = 0; ed = 0; ek = 1; rptr = ra;
            end
            if (pv) begin mm[pa] = pd; kn[pa] = 1; end
            wa = wrst ? 0 : wptr;
            pv = wen;
            if (wen) begin pa = wa; pd = wd; wptr = (wa + 1) % W; end
            else wptr = wa;
        end
        #1;
        exp_q.push_back({eoe, ek, ed});
        tag_q.push_back(tag);
    endtask

    // Monitor: compares the output after each edge with the oldest expectation.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [9:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_oe !== e[9] || (e[8] && rd_data !== e[7:0])) begin
                errors++;
                $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
                         t, rd_oe, rd_data, e[9], e[7:0]);
            end
        end
    end

    initial begin
        for (int i = 0; i < W; i++) kn[i] = 0;
        // R9: power-on reset, output off
        for (int i = 0; i < 3; i++) step(0, 0, 0, 8'h00, 1, 0, "R9");
        // R1, R6: fill the whole line, pointer wraps to 0
        for (int i = 0; i < W; i++) step(1, 1, 0, 8'(i * 7 + 3), 0, 0, "R1");
        // R9, R3: reads after release start at word 0
        for (int i = 0; i < 4; i++) step(1, 0, 0, 8'h00, 1, 0, "R9 R3");
        // R4: read disabled, pointer holds, output off
        for (int i = 0; i < 3; i++) step(1, 0, 0, 8'h00, 0, 0, "R4");
        for (int i = 0; i < 2; i++) step(1, 0, 0, 8'h00, 1, 0, "R4 R3");
        // R2: disabled writes change nothing
        for (int i = 0; i < 3; i++) step(1, 0, 0, 8'hEE, 0, 0, "R2");
        step(1, 1, 0, 8'h11, 0, 0, "R1");
        step(1, 1, 0, 8'h12, 0, 0, "R1");
        step(1, 0, 0, 8'h00, 0, 0, "R2");
        // R5: read reset with enable reads word 0, then 1, then 2 (untouched, R2)
        step(1, 0, 0, 8'h00, 1, 1, "R5");
        step(1, 0, 0, 8'h00, 1, 0, "R5");
        step(1, 0, 0, 8'h00, 1, 0, "R2");
        // R7: write word 0 and read it on the same, next and later edges
        step(1, 1, 1, 8'h55, 1, 1, "R7");
        step(1, 0, 0, 8'h00, 1, 1, "R7");
        step(1, 0, 0, 8'h00, 1, 1, "R7");
        // R10: read reset while disabled, then enabled read gives word 0
        step(1, 0, 0, 8'h00, 1, 0, "R10");
        step(1, 0, 0, 8'h00, 0, 1, "R10");
        step(1, 0, 0, 8'h00, 1, 0, "R10");
        // R5: write reset alone leaves read pointer running
        step(1, 0, 1, 8'h00, 1, 0, "R5");
        step(1, 0, 0, 8'h00, 1, 0, "R5");
        // R8: both resets together, one-line delay; R6 at the read wrap
        for (int i = 0; i < W + 30; i++)
            step(1, 1, i == 0, 8'(i * 13 + 5), 1, i == 0,
                 (i >= W - 2 && i <= W + 2) ? "R6" : "R8");
        step(1, 0, 0, 8'h00, 0, 0, "R4");
        step(1, 0, 0, 8'h00, 0, 0, "R4");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule